// File: doc/BRIEF.md
# Request-Paced Receive DMA Channel

This block is one peripheral-to-memory DMA channel. A peripheral raises a request line whenever it has a received byte ready. For each request the channel reads one byte from a fixed peripheral data address, acknowledges the request, and writes the byte to a memory pointer that then advances by one. A byte counter counts down from the programmed length. When the counter reaches half of its start value, or reaches zero, a sticky flag is set. Each flag can raise the interrupt output through its own enable.

Software sets up the channel through a small register port while the channel is disabled. It writes the source address, the destination pointer and the byte count, then sets the enable bit. The channel runs until the count is exhausted. It then stays idle until software clears the enable bit, loads a new count and sets the enable bit again.

Top module: `dma_rx_channel`

## Requirements
- R1: After reset, every register reads zero, `irq`, both flag outputs, `per_ack` and `m_valid` are low. Register offsets: 0 control, 1 source address, 2 destination pointer, 3 remaining count, 4 flags.
- R2: While control bit 0 (enable) is clear, a held `per_req` produces no `per_ack` and no bus access.
- R3: For each serviced request, the channel issues a read (`m_write` low) at the source address. `per_ack` is high for exactly one cycle: the first cycle of that read.
- R4: The byte returned by the read is written (`m_write` high) to the destination pointer. The pointer then advances by one. The source address never changes on its own.
- R5: Register 3 reads the remaining count, which drops by one after each completed write.
- R6: Flags bit 0 (half) sets when the remaining count reaches the start count divided by two, rounded down. With a start count of 1, the half flag and the done flag set together.
- R7: Flags bit 1 (done) sets when the remaining count reaches zero. After that, requests are ignored.
- R8: `irq` is high when the half flag is set and control bit 1 is set, or when the done flag is set and control bit 2 is set. Flags still set with their enables clear.
- R9: Writing the flags register clears each flag whose bit is written as 1. Bits written as 0 leave their flag unchanged.
- R10: Enabling the channel with a count of zero starts no transfer and sets no flag.
- R11: While enabled, writes to registers 1, 2 and 3 are ignored.
- R12: Control bits 5:4 hold a priority value that reads back as written and does not change the transfers.
- R13: While a bus access waits for `m_ready`, `m_valid`, `m_write`, `m_addr` and `m_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral byte-ready request |
| per_ack | output | 1 | Request acknowledge, one cycle |
| m_valid | output | 1 | Bus access active |
| m_write | output | 1 | Bus access is a write |
| m_addr | output | 32 | Bus address |
| m_wdata | output | 8 | Bus write byte |
| m_rdata | input | 8 | Bus read byte |
| m_ready | input | 1 | Bus access completes this cycle |
| half_flag | output | 1 | Half-transfer flag |
| done_flag | output | 1 | Transfer-complete flag |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that the peripheral lowers its request once it has seen the acknowledge. They also assume that the source address is rewritten only while no read is in flight, and that the bus responder eventually raises `m_ready` for every access. The stimulus respects these assumptions. Each request is held only until its acknowledge is seen. Registers are programmed only while the channel is idle. The bench responder completes every access after a fixed number of wait cycles, zero to two.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int unsigned SEL_W = 3;
    localparam logic [SEL_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] OFS_SRC  = 3'd1;
    localparam logic [SEL_W-1:0] OFS_DST  = 3'd2;
    localparam logic [SEL_W-1:0] OFS_CNT  = 3'd3;
    localparam logic [SEL_W-1:0] OFS_FLAG = 3'd4;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_HIE_BIT  = 1;
    localparam int unsigned CTRL_CIE_BIT  = 2;
    localparam int unsigned CTRL_PRIO_LSB = 4;

    localparam int unsigned FLAG_HALF_BIT = 0;
    localparam int unsigned FLAG_DONE_BIT = 1;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mover_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32,
    parameter int unsigned PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             byte_done,
    output logic             run,
    output logic             chan_en,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr,
    output logic [CW-1:0]    remain,
    output logic [CW-1:0]    half_mark,
    output logic             half_flag,
    output logic             done_flag,
    output logic             irq
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          en;
        logic          hie;
        logic          cie;
        logic [PW-1:0] prio;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] left;
        logic [CW-1:0] mark;
        logic          half;
        logic          done;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            unique case (cfg_addr)
                OFS_CTRL: begin
                    s_d.en   = cfg_wdata[CTRL_EN_BIT];
                    s_d.hie  = cfg_wdata[CTRL_HIE_BIT];
                    s_d.cie  = cfg_wdata[CTRL_CIE_BIT];
                    s_d.prio = cfg_wdata[CTRL_PRIO_LSB +: PW];
                    if (!s_q.en && cfg_wdata[CTRL_EN_BIT]) begin
                        s_d.mark = s_q.left >> 1;
                    end
                end
                OFS_SRC:  if (!s_q.en) s_d.src  = AW'(cfg_wdata);
                OFS_DST:  if (!s_q.en) s_d.dst  = AW'(cfg_wdata);
                OFS_CNT:  if (!s_q.en) s_d.left = CW'(cfg_wdata);
                OFS_FLAG: begin
                    if (cfg_wdata[FLAG_HALF_BIT]) s_d.half = 1'b0;
                    if (cfg_wdata[FLAG_DONE_BIT]) s_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware updates come last so a set wins over a same-cycle clear
        if (byte_done && (s_q.left != '0)) begin
            s_d.left = s_q.left - ONE;
            s_d.dst  = s_q.dst + AW'(1);
            if ((s_q.left - ONE) == s_q.mark) s_d.half = 1'b1;
            if (s_q.left == ONE)              s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            OFS_CTRL: begin
                cfg_rdata[CTRL_EN_BIT]           = s_q.en;
                cfg_rdata[CTRL_HIE_BIT]          = s_q.hie;
                cfg_rdata[CTRL_CIE_BIT]          = s_q.cie;
                cfg_rdata[CTRL_PRIO_LSB +: PW]   = s_q.prio;
            end
            OFS_SRC:  cfg_rdata = DW'(s_q.src);
            OFS_DST:  cfg_rdata = DW'(s_q.dst);
            OFS_CNT:  cfg_rdata = DW'(s_q.left);
            OFS_FLAG: begin
                cfg_rdata[FLAG_HALF_BIT] = s_q.half;
                cfg_rdata[FLAG_DONE_BIT] = s_q.done;
            end
            default: cfg_rdata = '0;
        endcase
    end

    assign run       = s_q.en && (s_q.left != '0);
    assign chan_en   = s_q.en;
    assign src_addr  = s_q.src;
    assign dst_addr  = s_q.dst;
    assign remain    = s_q.left;
    assign half_mark = s_q.mark;
    assign half_flag = s_q.half;
    assign done_flag = s_q.done;
    assign irq       = (s_q.half && s_q.hie) || (s_q.done && s_q.cie);
endmodule

// File: rtl/dma_chan_mover.sv
module dma_chan_mover
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          per_req,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    output logic          per_ack,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [BW-1:0] m_wdata,
    input  logic [BW-1:0] m_rdata,
    input  logic          m_ready,
    output logic          byte_done
);
    typedef struct packed {
        mover_state_e  st;
        logic          first;
        logic [AW-1:0] addr;
        logic [BW-1:0] data;
    } mover_t;

    mover_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        byte_done = 1'b0;
        unique case (s_q.st)
            MV_IDLE: begin
                if (run && per_req) begin
                    s_d.st    = MV_READ;
                    s_d.first = 1'b1;
                    s_d.addr  = src_addr;
                end
            end
            MV_READ: begin
                s_d.first = 1'b0;
                if (m_ready) begin
                    s_d.st   = MV_WRITE;
                    s_d.data = m_rdata;
                    s_d.addr = dst_addr;
                end
            end
            MV_WRITE: begin
                if (m_ready) begin
                    s_d.st    = MV_IDLE;
                    byte_done = 1'b1;
                end
            end
            default: s_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign m_valid = (s_q.st != MV_IDLE);
    assign m_write = (s_q.st == MV_WRITE);
    assign m_addr  = s_q.addr;
    assign m_wdata = s_q.data;
    assign per_ack = (s_q.st == MV_READ) && s_q.first;
endmodule

// File: rtl/dma_rx_channel.sv
module dma_rx_channel
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 8,
    parameter int unsigned PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             per_req,
    output logic             per_ack,
    output logic             m_valid,
    output logic             m_write,
    output logic [AW-1:0]    m_addr,
    output logic [BW-1:0]    m_wdata,
    input  logic [BW-1:0]    m_rdata,
    input  logic             m_ready,
    output logic             half_flag,
    output logic             done_flag,
    output logic             irq
);
    logic          run;
    logic          chan_en;
    logic          byte_done;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;
    logic [CW-1:0] remain;
    logic [CW-1:0] half_mark;

    dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW), .PW(PW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .byte_done (byte_done),
        .run       (run),
        .chan_en   (chan_en),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .remain    (remain),
        .half_mark (half_mark),
        .half_flag (half_flag),
        .done_flag (done_flag),
        .irq       (irq)
    );

    dma_chan_mover #(.AW(AW), .BW(BW)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .per_req   (per_req),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .per_ack   (per_ack),
        .m_valid   (m_valid),
        .m_write   (m_write),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_rdata   (m_rdata),
        .m_ready   (m_ready),
        .byte_done (byte_done)
    );
endmodule

// File: rtl/dma_rx_channel_chk.sv
module dma_rx_channel_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16,
    parameter int unsigned BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          per_ack,
    input logic          m_valid,
    input logic          m_write,
    input logic          m_ready,
    input logic [AW-1:0] m_addr,
    input logic [BW-1:0] m_wdata,
    input logic          chan_en,
    input logic [CW-1:0] remain,
    input logic [CW-1:0] half_mark,
    input logic          half_flag,
    input logic          done_flag
);
    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr) && $stable(m_wdata)));

    // R3
    ack_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> (m_valid && !m_write));

    // R3
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    // R2
    start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(chan_en));

    // R6
    half_at_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_flag) |-> (remain == half_mark));

    // R7
    done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (remain == '0));

    // R10
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && (remain == '0) && !m_valid) |=> !m_valid);
endmodule

bind dma_rx_channel dma_rx_channel_chk #(.AW(AW), .CW(CW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_ack   (per_ack),
    .m_valid   (m_valid),
    .m_write   (m_write),
    .m_ready   (m_ready),
    .m_addr    (m_addr),
    .m_wdata   (m_wdata),
    .chan_en   (chan_en),
    .remain    (remain),
    .half_mark (half_mark),
    .half_flag (half_flag),
    .done_flag (done_flag)
);

// File: tb/dma_rx_channel_bench.sv
module dma_rx_channel_bench;
    localparam logic [31:0] SRC = 32'h4000_1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic        m_valid, m_write, m_ready;
    logic [31:0] m_addr;
    logic [7:0]  m_wdata;
    logic [7:0]  m_rdata;
    logic        half_flag, done_flag, irq;

    logic [7:0]  per_data = '0;
    logic [3:0]  wait_n = '0;
    logic [3:0]  lat;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    dma_rx_channel u_dma_rx_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
        .per_ack(per_ack), .m_valid(m_valid), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ready(m_ready), .half_flag(half_flag), .done_flag(done_flag),
        .irq(irq)
    );

    // bus responder with a fixed number of wait cycles
    assign m_ready = m_valid && (lat == wait_n);
    assign m_rdata = per_data;
    always_ff @(posedge clk) begin
        if (!rst_n)                  lat <= '0;
        else if (m_valid && !m_ready) lat <= lat + 4'd1;
        else                         lat <= '0;
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic move_byte(input logic [7:0] d, input logic [31:0] dst);
        int n;
        per_data = d;
        @(negedge clk);
        per_req = 1'b1;
        n = 0;
        while (!per_ack && n < 50) begin @(negedge clk); n++; end
        check_eq("R3", "ack seen", {31'd0, per_ack}, 32'd1);
        check_eq("R3", "read address", m_addr, SRC);
        check_eq("R3", "read direction", {31'd0, m_write}, 32'd0);
        per_req = 1'b0;
        n = 0;
        while (!(m_valid && m_write && m_ready) && n < 50) begin
            if (m_valid && m_write) check_eq("R13", "held write address", m_addr, dst);
            @(negedge clk); n++;
        end
        check_eq("R4", "write address", m_addr, dst);
        check_eq("R4", "write data", {24'd0, m_wdata}, {24'd0, d});
        @(negedge clk);
    endtask

    task automatic expect_ignored(input string req);
        int hits;
        hits = 0;
        @(negedge clk);
        per_req = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (per_ack || m_valid) hits++;
        end
        per_req = 1'b0;
        check_eq(req, "activity on ignored request", hits, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), v);
            check_eq("R1", "register after reset", v, 32'd0);
        end
        check_eq("R1", "outputs after reset",
                 {27'd0, irq, half_flag, done_flag, per_ack, m_valid}, 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] v;
        logic [7:0] bytes [4] = '{8'hA5, 8'h3C, 8'h0F, 8'hF0};
        reg_wr(3'd1, SRC);
        reg_wr(3'd2, 32'h100);
        reg_wr(3'd3, 32'd4);
        reg_wr(3'd0, 32'h26);
        expect_ignored("R2");
        reg_wr(3'd0, 32'h27);
        for (int i = 0; i < 4; i++) begin
            move_byte(bytes[i], 32'h100 + 32'(i));
            reg_rd(3'd3, v);
            check_eq("R5", "remaining count", v, 32'(3 - i));
            check_eq("R6", "half flag", {31'd0, half_flag}, {31'd0, (i >= 1)});
            check_eq("R8", "irq", {31'd0, irq}, {31'd0, (i >= 1)});
            check_eq("R7", "done flag", {31'd0, done_flag}, {31'd0, (i == 3)});
        end
        reg_rd(3'd2, v);
        check_eq("R4", "pointer advanced", v, 32'h104);
        reg_rd(3'd1, v);
        check_eq("R4", "source unchanged", v, SRC);
        reg_rd(3'd0, v);
        check_eq("R12", "control with priority", v, 32'h27);
        expect_ignored("R7");
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_wr(3'd4, 32'd0);
        reg_rd(3'd4, v);
        check_eq("R9", "zero write keeps flags", v, 32'd3);
        reg_wr(3'd4, 32'd1);
        reg_rd(3'd4, v);
        check_eq("R9", "half cleared only", v, 32'd2);
        check_eq("R8", "irq from done", {31'd0, irq}, 32'd1);
        reg_wr(3'd4, 32'd2);
        reg_rd(3'd4, v);
        check_eq("R9", "done cleared", v, 32'd0);
        check_eq("R8", "irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_gated();
        logic [31:0] v;
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd3, 32'd5);
        reg_wr(3'd2, 32'h20);
        reg_wr(3'd0, 32'h1);
        reg_wr(3'd3, 32'd9);
        reg_wr(3'd2, 32'h3F);
        reg_wr(3'd1, 32'h0);
        reg_rd(3'd3, v); check_eq("R11", "count locked", v, 32'd5);
        reg_rd(3'd2, v); check_eq("R11", "pointer locked", v, 32'h20);
        reg_rd(3'd1, v); check_eq("R11", "source locked", v, SRC);
        wait_n = 4'd2;
        for (int i = 0; i < 5; i++) begin
            move_byte(8'(8'h11 * (i + 1)), 32'h20 + 32'(i));
            check_eq("R6", "half flag odd count", {31'd0, half_flag}, {31'd0, (i >= 2)});
            check_eq("R8", "irq gated off", {31'd0, irq}, 32'd0);
        end
        check_eq("R7", "done flag", {31'd0, done_flag}, 32'd1);
        reg_rd(3'd2, v); check_eq("R4", "pointer after five", v, 32'h25);
        reg_wr(3'd0, 32'h7);
        check_eq("R8", "irq after enable", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd4, 32'd3);
        reg_wr(3'd3, 32'd0);
        reg_wr(3'd0, 32'h7);
        expect_ignored("R10");
        reg_rd(3'd4, v);
        check_eq("R10", "no flags", v, 32'd0);
        check_eq("R10", "no irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd3, 32'd1);
        reg_wr(3'd2, 32'h30);
        reg_wr(3'd0, 32'h7);
        wait_n = 4'd1;
        move_byte(8'h5A, 32'h30);
        reg_rd(3'd4, v);
        check_eq("R6", "both flags on count of one", v, 32'd3);
        reg_rd(3'd3, v);
        check_eq("R5", "count emptied", v, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_w1c();
        t_gated();
        t_zero();
        t_single();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule